// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Extended Opcode Decoder

This block is a test access port controller for boundary-scan testing. It runs the sixteen-state test-port state machine on the test clock and holds a ten-bit instruction register. The decoded opcode selects the data register that sits between the serial input and the serial output. The choices are a one-bit bypass cell, a 32-bit identification word, a 32-bit user-defined word, a 22-bit configuration boot address, or an external boundary-scan chain that connects through strobe and return ports.

Beyond the standard register selection, several opcodes drive side-effect controls into the rest of the chip:
- pin tristate and pin hold;
- a single-cycle reconfiguration request;
- a sticky select between the external and the internal configuration clock;
- a sticky disengage flag for the active configuration controller;
- an I/O reconfiguration request that is gated by a status input.

The boundary cells, the flash controller and the oscillators sit outside this block and connect to it through plain ports.

Top module: `jtag_tap_ext`

## Requirements
- R1: The state machine advances on the rising edge of `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low forces Test-Logic-Reset asynchronously.
- R2: In Test-Logic-Reset and after `trst_n`, the current opcode is 0x006. This opcode selects the 32-bit identification word (parameter `ID_VALUE`), which Shift-DR sends out least significant bit first.
- R3: Capture-IR loads the value 0x001 into the instruction shift register. Shift-IR moves bits from `tdi` toward `tdo` least significant bit first. Update-IR makes the shifted value the current opcode.
- R4: Opcode 0x3FF selects the one-bit bypass cell, which loads 0 at Capture-DR. Every opcode not listed in R2 and R5–R11 does the same.
- R5: Opcode 0x007 selects a 32-bit register that loads `user_code` at Capture-DR and shifts it out least significant bit first.
- R6: Opcodes 0x005 and 0x00F select the external chain. While either is current, `chain_sel` is high and `chain_capture`, `chain_shift` and `chain_update` follow Capture-DR, Shift-DR and Update-DR. The bits on `tdo` come from `chain_so`. `chain_ext` is high only for 0x00F.
- R7: While 0x00B is current, `pins_hiz` is high. While 0x00A is current, `pins_hold` is high. Both opcodes select the bypass cell.
- R8: Opcode 0x270 selects a 22-bit register that captures the present `boot_addr`. At Update-DR the shifted value is copied to `boot_addr`, and `boot_load` pulses for one `tck` cycle.
- R9: While 0x001 is current, each entry into Run-Test/Idle raises `reconfig_pulse` for exactly one `tck` cycle.
- R10: Update-IR of 0x1EE sets `ext_clk_sel` and Update-IR of 0x2EE clears it. Update-IR of 0x2D0 sets `cfg_disengage` and Update-IR of 0x2B0 clears it. Neither flag changes at any other time except that `trst_n` low clears both.
- R11: While 0x00D is current, `io_reconfig_req` equals `io_cfg_ok`, and the bypass cell is selected.
- R12: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is high only while the state is Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| user_code | input | ID_W | Word captured by the user-code opcode |
| io_cfg_ok | input | 1 | Status that permits I/O reconfiguration |
| chain_so | input | 1 | Return bit of the external boundary chain |
| chain_sel | output | 1 | External chain is the selected data register |
| chain_ext | output | 1 | External-test mode: chain drives the pins |
| chain_capture | output | 1 | Chain capture strobe |
| chain_shift | output | 1 | Chain shift enable |
| chain_update | output | 1 | Chain update strobe |
| pins_hiz | output | 1 | Tristate all pins |
| pins_hold | output | 1 | Hold pins at the chain's latched values |
| reconfig_pulse | output | 1 | One-cycle reconfiguration request |
| ext_clk_sel | output | 1 | Configuration clock from the external user clock |
| cfg_disengage | output | 1 | Idle the active configuration controller |
| io_reconfig_req | output | 1 | I/O reconfiguration request |
| boot_addr | output | BOOT_W | Loaded configuration boot address |
| boot_load | output | 1 | One-cycle strobe when `boot_addr` is loaded |

## Verification
The bench uses the default parameters: a 10-bit instruction register, 32-bit identification and user words, a 22-bit boot register, and the asynchronous reset present. With these values all 1024 opcodes can be swept one by one. For each opcode the bench checks:
- the captured instruction pattern;
- a 40-bit data shift, whose result shows both the selected register's capture value and its length;
- every side-effect output;
- the pulse counts for `reconfig_pulse`, `boot_load` and `chain_update`.

An 8-cell chain model in the bench stands in for the boundary cells. Separate directed sequences cover:
- reset through `tms` from inside the data path;
- the clearing effect of `trst_n`;
- the gating by `io_cfg_ok`;
- the falling-edge timing of `tdo`.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      S_RESET, S_IDLE,
      S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAUSE_DR, S_EX2_DR, S_UPD_DR,
      S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAUSE_IR, S_EX2_IR, S_UPD_IR
   } tap_state_e;

   typedef enum logic [2:0] {
      DR_BYP, DR_ID, DR_USER, DR_BOOT, DR_CHAIN
   } dr_sel_e;

   // opcode map (ten significant bits)
   localparam logic [9:0] OP_RECONF  = 10'h001;
   localparam logic [9:0] OP_SAMPLE  = 10'h005;
   localparam logic [9:0] OP_IDENT   = 10'h006;
   localparam logic [9:0] OP_USER    = 10'h007;
   localparam logic [9:0] OP_HOLD    = 10'h00A;
   localparam logic [9:0] OP_FLOAT   = 10'h00B;
   localparam logic [9:0] OP_IOCFG   = 10'h00D;
   localparam logic [9:0] OP_EXTEST  = 10'h00F;
   localparam logic [9:0] OP_EXTCLK  = 10'h1EE;
   localparam logic [9:0] OP_BOOTADR = 10'h270;
   localparam logic [9:0] OP_ENGAGE  = 10'h2B0;
   localparam logic [9:0] OP_DISENG  = 10'h2D0;
   localparam logic [9:0] OP_INTCLK  = 10'h2EE;
   localparam logic [9:0] OP_BYPASS  = 10'h3FF;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         S_RESET:    return m ? S_RESET    : S_IDLE;
         S_IDLE:     return m ? S_SEL_DR   : S_IDLE;
         S_SEL_DR:   return m ? S_SEL_IR   : S_CAP_DR;
         S_CAP_DR:   return m ? S_EX1_DR   : S_SH_DR;
         S_SH_DR:    return m ? S_EX1_DR   : S_SH_DR;
         S_EX1_DR:   return m ? S_UPD_DR   : S_PAUSE_DR;
         S_PAUSE_DR: return m ? S_EX2_DR   : S_PAUSE_DR;
         S_EX2_DR:   return m ? S_UPD_DR   : S_SH_DR;
         S_UPD_DR:   return m ? S_SEL_DR   : S_IDLE;
         S_SEL_IR:   return m ? S_RESET    : S_CAP_IR;
         S_CAP_IR:   return m ? S_EX1_IR   : S_SH_IR;
         S_SH_IR:    return m ? S_EX1_IR   : S_SH_IR;
         S_EX1_IR:   return m ? S_UPD_IR   : S_PAUSE_IR;
         S_PAUSE_IR: return m ? S_EX2_IR   : S_PAUSE_IR;
         S_EX2_IR:   return m ? S_UPD_IR   : S_SH_IR;
         S_UPD_IR:   return m ? S_SEL_DR   : S_IDLE;
         default:    return S_RESET;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= S_RESET;
      else        state <= tap_next(state, tms);
   end

   // R1: from Select-IR-Scan a high tms always lands in Test-Logic-Reset
   p_sel_ir_reset_r1: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_SEL_IR && tms) |=> (state == S_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int IR_W = 10
)(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir_q,
   output logic [IR_W-1:0] ir_sh
);

   localparam logic [IR_W-1:0] RST_OP  = IR_W'(OP_IDENT);
   localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

   initial begin
      if (IR_W < 10) $error("tap_ir: IR_W must hold a ten-bit opcode");
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_q  <= RST_OP;
         ir_sh <= CAP_PAT;
      end else begin
         case (state)
            S_RESET:  ir_q  <= RST_OP;
            S_CAP_IR: ir_sh <= CAP_PAT;
            S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            S_UPD_IR: ir_q  <= ir_sh;
            default:  ;
         endcase
      end
   end

   // R2: leaving Test-Logic-Reset the identification opcode is current
   p_tlr_ident_r2: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_RESET) |=> (ir_q == RST_OP));

   // R3: Capture-IR leaves the fixed pattern in the shift stage
   p_cap_pattern_r3: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_CAP_IR) |=> (ir_sh == CAP_PAT));

endmodule

// File: rtl/tap_decode.sv
module tap_decode
   import tap_pkg::*;
#(
   parameter int IR_W = 10
)(
   input  logic [IR_W-1:0] ir_q,
   input  logic            io_cfg_ok,
   output dr_sel_e         sel,
   output logic            hiz,
   output logic            hold,
   output logic            ext_mode,
   output logic            reconf,
   output logic            io_req
);

   always_comb begin
      sel      = DR_BYP;
      hiz      = 1'b0;
      hold     = 1'b0;
      ext_mode = 1'b0;
      reconf   = 1'b0;
      io_req   = 1'b0;
      case (ir_q)
         IR_W'(OP_IDENT):   sel = DR_ID;
         IR_W'(OP_USER):    sel = DR_USER;
         IR_W'(OP_BOOTADR): sel = DR_BOOT;
         IR_W'(OP_SAMPLE):  sel = DR_CHAIN;
         IR_W'(OP_EXTEST):  begin sel = DR_CHAIN; ext_mode = 1'b1; end
         IR_W'(OP_FLOAT):   hiz    = 1'b1;
         IR_W'(OP_HOLD):    hold   = 1'b1;
         IR_W'(OP_RECONF):  reconf = 1'b1;
         IR_W'(OP_IOCFG):   io_req = io_cfg_ok;
         default:           ;
      endcase
   end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int              ID_W     = 32,
   parameter int              BOOT_W   = 22,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B_3C4D
)(
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tdi,
   input  tap_state_e        state,
   input  dr_sel_e           sel,
   input  logic [ID_W-1:0]   user_code,
   input  logic              chain_so,
   output logic              dr_so,
   output logic              chain_capture,
   output logic              chain_shift,
   output logic              chain_update,
   output logic [BOOT_W-1:0] boot_addr,
   output logic              boot_load
);

   initial begin
      if (ID_W < 2)         $error("tap_dr: ID_W too small");
      if (BOOT_W < 1)       $error("tap_dr: BOOT_W must be positive");
      if (ID_VALUE[0] != 1) $error("tap_dr: identification LSB must be 1");
   end

   logic              byp;
   logic [ID_W-1:0]   id_sh, user_sh;
   logic [BOOT_W-1:0] boot_sh;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp       <= 1'b0;
         id_sh     <= '0;
         user_sh   <= '0;
         boot_sh   <= '0;
         boot_addr <= '0;
         boot_load <= 1'b0;
      end else begin
         boot_load <= 1'b0;
         case (state)
            S_CAP_DR: begin
               case (sel)
                  DR_BYP:  byp     <= 1'b0;
                  DR_ID:   id_sh   <= ID_VALUE;
                  DR_USER: user_sh <= user_code;
                  DR_BOOT: boot_sh <= boot_addr;
                  default: ;
               endcase
            end
            S_SH_DR: begin
               case (sel)
                  DR_BYP:  byp     <= tdi;
                  DR_ID:   id_sh   <= {tdi, id_sh[ID_W-1:1]};
                  DR_USER: user_sh <= {tdi, user_sh[ID_W-1:1]};
                  DR_BOOT: boot_sh <= {tdi, boot_sh[BOOT_W-1:1]};
                  default: ;
               endcase
            end
            S_UPD_DR: begin
               if (sel == DR_BOOT) begin
                  boot_addr <= boot_sh;
                  boot_load <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         DR_ID:    dr_so = id_sh[0];
         DR_USER:  dr_so = user_sh[0];
         DR_BOOT:  dr_so = boot_sh[0];
         DR_CHAIN: dr_so = chain_so;
         default:  dr_so = byp;
      endcase
   end

   assign chain_capture = (sel == DR_CHAIN) && (state == S_CAP_DR);
   assign chain_shift   = (sel == DR_CHAIN) && (state == S_SH_DR);
   assign chain_update  = (sel == DR_CHAIN) && (state == S_UPD_DR);

   // R8: the load strobe only follows an Update-DR
   p_boot_load_r8: assert property (@(posedge tck) disable iff (!rst_n)
      boot_load |-> ($past(state) == S_UPD_DR));

   // R8: boot address only moves together with its strobe
   p_boot_stable_r8: assert property (@(posedge tck) disable iff (!rst_n)
      !boot_load |-> $stable(boot_addr));

endmodule

// File: rtl/jtag_tap_ext.sv
module jtag_tap_ext
   import tap_pkg::*;
#(
   parameter int              IR_W     = 10,
   parameter int              ID_W     = 32,
   parameter int              BOOT_W   = 22,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B_3C4D,
   parameter bit              USE_TRST = 1'b1
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_oe,
   input  logic [ID_W-1:0]   user_code,
   input  logic              io_cfg_ok,
   input  logic              chain_so,
   output logic              chain_sel,
   output logic              chain_ext,
   output logic              chain_capture,
   output logic              chain_shift,
   output logic              chain_update,
   output logic              pins_hiz,
   output logic              pins_hold,
   output logic              reconfig_pulse,
   output logic              ext_clk_sel,
   output logic              cfg_disengage,
   output logic              io_reconfig_req,
   output logic [BOOT_W-1:0] boot_addr,
   output logic              boot_load
);

   logic rst_n;

   generate
      if (USE_TRST) begin : g_trst
         assign rst_n = trst_n;
      end else begin : g_no_trst
         assign rst_n = 1'b1;
      end
   endgenerate

   tap_state_e      state;
   dr_sel_e         sel;
   logic [IR_W-1:0] ir_q, ir_sh;
   logic            dr_so, reconf_op, was_idle;

   tap_fsm u_fsm (.tck, .rst_n, .tms, .state);

   tap_ir #(.IR_W(IR_W)) u_ir (.tck, .rst_n, .tdi, .state, .ir_q, .ir_sh);

   tap_decode #(.IR_W(IR_W)) u_dec (
      .ir_q, .io_cfg_ok, .sel, .hiz(pins_hiz), .hold(pins_hold),
      .ext_mode(chain_ext), .reconf(reconf_op), .io_req(io_reconfig_req));

   tap_dr #(.ID_W(ID_W), .BOOT_W(BOOT_W), .ID_VALUE(ID_VALUE)) u_dr (
      .tck, .rst_n, .tdi, .state, .sel, .user_code, .chain_so, .dr_so,
      .chain_capture, .chain_shift, .chain_update, .boot_addr, .boot_load);

   assign chain_sel = (sel == DR_CHAIN);

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (state == S_SH_IR) ? ir_sh[0] : dr_so;
         tdo_oe <= (state == S_SH_IR) || (state == S_SH_DR);
      end
   end

   // sticky configuration flags and reconfiguration pulse
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ext_clk_sel    <= 1'b0;
         cfg_disengage  <= 1'b0;
         was_idle       <= 1'b0;
         reconfig_pulse <= 1'b0;
      end else begin
         was_idle       <= (state == S_IDLE);
         reconfig_pulse <= reconf_op && (state == S_IDLE) && !was_idle;
         if (state == S_UPD_IR) begin
            case (ir_sh)
               IR_W'(OP_EXTCLK): ext_clk_sel   <= 1'b1;
               IR_W'(OP_INTCLK): ext_clk_sel   <= 1'b0;
               IR_W'(OP_DISENG): cfg_disengage <= 1'b1;
               IR_W'(OP_ENGAGE): cfg_disengage <= 1'b0;
               default:          ;
            endcase
         end
      end
   end

   // R9: the reconfiguration request never lasts two cycles
   p_pulse_single_r9: assert property (@(posedge tck) disable iff (!rst_n)
      reconfig_pulse |=> !reconfig_pulse);

   // R10: sticky flags hold outside Update-IR
   p_sticky_r10: assert property (@(posedge tck) disable iff (!rst_n)
      (state != S_UPD_IR) |=> ($stable(ext_clk_sel) && $stable(cfg_disengage)));

   // R12: output enable only while a shift state is current
   p_oe_shift_r12: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));

   // R7: pin-control opcodes leave the bypass cell selected
   p_pinctl_bypass_r7: assert property (@(posedge tck) disable iff (!rst_n)
      (pins_hiz || pins_hold) |-> (sel == DR_BYP));

endmodule

// File: tb/jtag_tap_ext_tb.sv
`timescale 1ns/1ps
module jtag_tap_ext_tb;

   localparam logic [31:0] ID   = 32'h1A2B_3C4D;
   localparam logic [31:0] USER = 32'h9E37_79B9;
   localparam logic [7:0]  CHAIN_CAP = 8'h5A;

   logic        tck = 1'b0;
   logic        trst_n, tms, tdi, io_cfg_ok, chain_so;
   logic [31:0] user_code;
   logic        tdo, tdo_oe, chain_sel, chain_ext, chain_capture, chain_shift, chain_update;
   logic        pins_hiz, pins_hold, reconfig_pulse, ext_clk_sel, cfg_disengage, io_reconfig_req;
   logic [21:0] boot_addr;
   logic        boot_load;

   always #2.5 tck = ~tck;

   jtag_tap_ext u_dut (
      .tck, .trst_n, .tms, .tdi, .tdo, .tdo_oe, .user_code, .io_cfg_ok, .chain_so,
      .chain_sel, .chain_ext, .chain_capture, .chain_shift, .chain_update,
      .pins_hiz, .pins_hold, .reconfig_pulse, .ext_clk_sel, .cfg_disengage,
      .io_reconfig_req, .boot_addr, .boot_load);

   // 8-cell boundary chain stand-in
   logic [7:0] chain;
   always @(posedge tck) begin
      if (chain_capture)    chain <= CHAIN_CAP;
      else if (chain_shift) chain <= {tdi, chain[7:1]};
   end
   assign chain_so = chain[0];

   int pulse_cnt, load_cnt, upd_cnt;
   always @(negedge tck) begin
      if (reconfig_pulse) pulse_cnt++;
      if (boot_load)      load_cnt++;
      if (chain_update)   upd_cnt++;
   end

   int n_run = 0, n_fail = 0;
   logic [21:0] boot_model = '0;
   logic        ext_model = 1'b0, dis_model = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o, output logic oe);
      @(negedge tck); #1;
      o = tdo; oe = tdo_oe;
      tms = m; tdi = d;
   endtask

   task automatic step0(input logic m);
      logic o, oe;
      step(m, 1'b0, o, oe);
   endtask

   task automatic shift_ir(input logic [9:0] code, output logic [9:0] cap, output bit oe_ok);
      logic o, oe;
      oe_ok = 1;
      step0(1); step0(1); step0(0); step0(0);
      for (int i = 0; i < 10; i++) begin
         step(i == 9, code[i], o, oe);
         cap[i] = o;
         if (!oe) oe_ok = 0;
      end
      step0(1); step0(0);
   endtask

   task automatic shift_dr(input logic [39:0] din, output logic [39:0] dout);
      logic o, oe;
      step0(1); step0(0); step0(0);
      for (int i = 0; i < 40; i++) begin
         step(i == 39, din[i], o, oe);
         dout[i] = o;
      end
      step0(1); step0(0);
   endtask

   task automatic settle();
      step0(0); step0(0); step0(0);
      @(negedge tck); #1;
   endtask

   function automatic int kind_of(input logic [9:0] c);
      case (c)
         10'h006: return 1;
         10'h007: return 2;
         10'h270: return 3;
         10'h005, 10'h00F: return 4;
         default: return 0;
      endcase
   endfunction

   task automatic run_code(input logic [9:0] c);
      logic [9:0]  cap;
      logic [39:0] din, dout, exp;
      bit          oe_ok;
      int          k;
      k = kind_of(c);
      pulse_cnt = 0; load_cnt = 0; upd_cnt = 0;
      shift_ir(c, cap, oe_ok);
      if (c == 10'h1EE) ext_model = 1;
      if (c == 10'h2EE) ext_model = 0;
      if (c == 10'h2D0) dis_model = 1;
      if (c == 10'h2B0) dis_model = 0;
      din = {c[7:0], (32'(c) * 32'h0100_0193) ^ 32'hA5A5_0F0F};
      shift_dr(din, dout);
      case (k)
         1:       exp = {din[7:0], ID};
         2:       exp = {din[7:0], USER};
         3:       exp = {din[17:0], boot_model};
         4:       exp = {din[31:0], CHAIN_CAP};
         default: exp = {din[38:0], 1'b0};
      endcase
      if (k == 3) boot_model = din[39:18];
      settle();
      chk(cap == 10'h001, "R3 capture-IR pattern", cap, 10'h001);
      chk(oe_ok, "R12 oe in Shift-IR", oe_ok, 1);
      chk(dout == exp, (k == 0) ? "R4 bypass/undefined" : (k == 1) ? "R2 ident" :
          (k == 2) ? "R5 usercode" : (k == 3) ? "R8 boot capture" : "R6 chain data",
          dout, exp);
      chk(pins_hiz == (c == 10'h00B), "R7 pins_hiz", pins_hiz, c == 10'h00B);
      chk(pins_hold == (c == 10'h00A), "R7 pins_hold", pins_hold, c == 10'h00A);
      chk(chain_sel == (k == 4), "R6 chain_sel", chain_sel, k == 4);
      chk(chain_ext == (c == 10'h00F), "R6 chain_ext", chain_ext, c == 10'h00F);
      chk(upd_cnt == ((k == 4) ? 1 : 0), "R6 chain_update count", upd_cnt, (k == 4) ? 1 : 0);
      chk(io_reconfig_req == 1'b0, "R11 gated by status low", io_reconfig_req, 0);
      chk(ext_clk_sel == ext_model, "R10 ext_clk_sel", ext_clk_sel, ext_model);
      chk(cfg_disengage == dis_model, "R10 cfg_disengage", cfg_disengage, dis_model);
      chk(pulse_cnt == ((c == 10'h001) ? 2 : 0), "R9 pulse cycles", pulse_cnt, (c == 10'h001) ? 2 : 0);
      chk(load_cnt == ((k == 3) ? 1 : 0), "R8 boot_load count", load_cnt, (k == 3) ? 1 : 0);
      chk(boot_addr == boot_model, "R8 boot_addr", boot_addr, boot_model);
      chk(tdo_oe == 1'b0, "R12 oe low in idle", tdo_oe, 0);
   endtask

   initial begin
      #(5.0 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [9:0]  cap;
      logic [39:0] dout;
      logic        o, oe;
      bit          oe_ok;
      trst_n = 0; tms = 1; tdi = 0; io_cfg_ok = 0; user_code = USER;
      repeat (3) @(negedge tck);
      #1;
      chk(tdo_oe == 0 && pins_hiz == 0 && ext_clk_sel == 0 && reconfig_pulse == 0,
          "R1 reset outputs", {tdo_oe, pins_hiz, ext_clk_sel, reconfig_pulse}, 0);
      trst_n = 1;
      step0(0);
      // R2: ident after reset
      shift_dr(40'h00_0000_0000, dout);
      chk(dout[31:0] == ID, "R2 ident after reset", dout[31:0], ID);

      // R12: tdo moves on the falling edge only
      step0(1); step0(0); step0(0);
      step(0, 0, o, oe);
      chk(o == ID[0] && oe, "R12 first bit", o, ID[0]);
      @(posedge tck); #1;
      chk(tdo == ID[0], "R12 held past rising edge", tdo, ID[0]);
      @(negedge tck); #1;
      chk(tdo == ID[1], "R12 changes at falling edge", tdo, ID[1]);
      tms = 1;
      step0(1); step0(0);

      // exhaustive opcode sweep
      for (int c = 0; c < 1024; c++) run_code(10'(c));

      // R11: status-gated I/O reconfiguration request
      shift_ir(10'h00D, cap, oe_ok);
      io_cfg_ok = 1; settle();
      chk(io_reconfig_req == 1, "R11 request with status high", io_reconfig_req, 1);
      io_cfg_ok = 0; #1;
      chk(io_reconfig_req == 0, "R11 request with status low", io_reconfig_req, 0);
      io_cfg_ok = 1;
      shift_dr(40'h12_3456_789A, dout);
      chk(dout == {40'h12_3456_789A, 1'b0} >> 0 & 40'hFF_FFFF_FFFF ? dout == {39'h12_3456_789A, 1'b0} : 0,
          "R11 bypass length", dout, {39'h12_3456_789A, 1'b0});
      io_cfg_ok = 0;

      // R1: tms reset from inside the data path clears pin tristate
      shift_ir(10'h00B, cap, oe_ok);
      settle();
      chk(pins_hiz == 1, "R7 hiz active", pins_hiz, 1);
      step0(1); step0(0); step0(0);
      repeat (5) step0(1);
      step0(0);
      settle();
      chk(pins_hiz == 0, "R1 tms reset drops hiz", pins_hiz, 0);
      shift_dr(40'h0, dout);
      chk(dout[31:0] == ID, "R1 ident after tms reset", dout[31:0], ID);

      // R10: sticky flags cleared by trst
      shift_ir(10'h1EE, cap, oe_ok);
      shift_ir(10'h2D0, cap, oe_ok);
      settle();
      chk(ext_clk_sel && cfg_disengage, "R10 flags set", {ext_clk_sel, cfg_disengage}, 2'b11);
      repeat (5) step0(1);
      step0(0); settle();
      chk(ext_clk_sel && cfg_disengage, "R10 flags survive tms reset", {ext_clk_sel, cfg_disengage}, 2'b11);
      trst_n = 0; #1;
      chk(!ext_clk_sel && !cfg_disengage, "R10 trst clears flags", {ext_clk_sel, cfg_disengage}, 0);
      @(negedge tck); trst_n = 1;
      step0(0);
      shift_dr(40'h0, dout);
      chk(dout[31:0] == ID, "R2 ident after trst", dout[31:0], ID);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule